// File: doc/BRIEF.md
# DRAM Strobe Decoder with Refresh Row Counter

This block is the device side of a behavioral sixteen-bit-wide dynamic memory. It oversamples the active-low row strobe, the two per-byte column strobes, the write enable, the output enable and a multiplexed address bus on a fast clock. From the order in which those strobes fall, it decides whether a cycle is an access, a row refresh or a refresh driven by the internal counter. A small internal array holds the data. The depth of that array is set by parameters, so the block fits on-chip storage.

The block is used as a synthesizable stand-in for a real part when a memory controller is being exercised. A falling row strobe latches the row. Each falling column strobe latches a column, so several columns can be reached under one row (page mode). Each column strobe acts as the byte enable for its own lane. A separate drive-enable output tells the surrounding pad logic when each byte lane should drive. Read data stays valid after a column strobe rises, for as long as the row strobe is low and output enable is asserted (extended data out).

When a column strobe is already low at the moment the row strobe falls, the cycle is a refresh. It uses a 9-bit internal row counter, which then advances by one and returns to zero after 512 refreshes.

Top module: `dram_strobe_model`

## Requirements
- R1: After reset, and on the clock after any edge at which the row strobe and both column strobes are all high, both lane drive enables are 0 and the counter output reads 0 after reset.
- R2: A row strobe fall with both column strobes high is a row-only refresh. While the row strobe stays low with both column strobes high, no lane is driven, the counter does not move and the stored data is unchanged.
- R3: During an access with write enable high and output enable low, a lane whose column strobe is low is driven with its stored byte one clock after the strobe falls. Lane 0 carries bits 7:0 and is selected by `lcas_n`. Lane 1 carries bits 15:8 and is selected by `ucas_n`. A lane that is not selected has drive enable 0 and shows 0 on its bits of `dq_out`.
- R4: With write enable low, only the lanes whose column strobes are low store their byte of `dq_in`. The byte of the other lane in the same word keeps its old value.
- R5: With write enable and output enable both high, no lane is driven.
- R6: If either column strobe is low when the row strobe falls, the cycle is a counter refresh. It makes no array write and does not start driving any lane. The counter output then increases by exactly one and wraps from 511 to 0.
- R7: In a read-modify-write cycle, the old word is driven first. When write enable then falls with the column strobes still low, the drives turn off and the new data is stored at the same location.
- R8: Row and column are taken modulo 2^ROW_BITS and 2^COL_BITS of the address bus. Addresses that differ only above those bits reach the same word.
- R9: With the row strobe low, a driven lane keeps its data and its drive enable after its column strobe rises. Both drives turn off one clock after output enable is sampled high.
- R10: Under one row strobe, successive column strobe falls latch new columns and return the words stored at those columns.
- R11: A write whose write enable is low when the column strobe falls (early write) never drives the lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Column strobe for lane 1 (bits 15:8), active low |
| lcas_n | input | 1 | Column strobe for lane 0 (bits 7:0), active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data; bytes of undriven lanes read 0 |
| dq_drive_lo | output | 1 | Drive enable for bits 7:0 |
| dq_drive_hi | output | 1 | Drive enable for bits 15:8 |
| cbr_row | output | REF_BITS | Next row for a counter refresh |

## Verification
The assertions assume that every strobe, the address and the write data are stable for at least one sampling clock between changes. They also assume that a column strobe never falls on the same sample as the row strobe, and that the write data is held while write enable is low. The bench changes all inputs only on the falling clock edge. It gives each phase of a strobe cycle at least one full clock, and it sets the address before the strobe that latches it. As a result, each rising edge sees a single, settled transition.

// File: rtl/dram_strobe_model.sv
module dram_strobe_model #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int REF_BITS = 9,
  parameter int ADDR_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              ucas_n,
  input  logic              lcas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic              dq_drive_lo,
  output logic              dq_drive_hi,
  output logic [REF_BITS-1:0] cbr_row
);
  localparam int AW    = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << AW;
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int COLS  = 1 << COL_BITS;

  typedef enum logic [1:0] {M_IDLE, M_ACCESS, M_REFRESH} mode_t;

  mode_t                mode;
  logic                 ras_q;
  logic [1:0]           cas_q;
  logic [ROW_BITS-1:0]  row_q;
  logic [COL_BITS-1:0]  col_q;
  logic [15:0]          rd_q;
  logic [1:0]           drive_q;
  logic [15:0]          mem [DEPTH];

  wire [1:0]          cas_n    = {ucas_n, lcas_n};
  wire                ras_fall = ras_q & ~ras_n;
  wire [1:0]          cas_fall = cas_q & ~cas_n;
  wire                access   = (mode == M_ACCESS) & ~ras_n;
  wire [ROW_BITS-1:0] row_in   = ROW_BITS'(addr % ADDR_W'(ROWS));
  wire [COL_BITS-1:0] col_in   = COL_BITS'(addr % ADDR_W'(COLS));
  wire [COL_BITS-1:0] col_eff  = (|cas_fall) ? col_in : col_q;
  wire [AW-1:0]       word     = {row_q, col_eff};
  wire                quiet    = (ras_n & (&cas_n)) | oe_n | ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q   <= 1'b1;
      cas_q   <= 2'b11;
      mode    <= M_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      cbr_row <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        if (&cas_n) begin
          mode  <= M_ACCESS;
          row_q <= row_in;
        end else begin
          mode    <= M_REFRESH;
          cbr_row <= cbr_row + REF_BITS'(1);
        end
      end else if (ras_n) begin
        mode <= M_IDLE;
      end
      if (access && (|cas_fall)) col_q <= col_in;
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < 2; g++)
      if (access && !cas_n[g] && !we_n)
        mem[word][8*g +: 8] <= dq_in[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      drive_q <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (access && !cas_n[g]) rd_q[8*g +: 8] <= mem[word][8*g +: 8];
        if (quiet) drive_q[g] <= 1'b0;
        else if (access && !cas_n[g]) drive_q[g] <= 1'b1;
      end
    end
  end

  assign dq_drive_lo = drive_q[0];
  assign dq_drive_hi = drive_q[1];
  assign dq_out      = {drive_q[1] ? rd_q[15:8] : 8'h00,
                        drive_q[0] ? rd_q[7:0]  : 8'h00};
endmodule

module dram_strobe_model_chk #(
  parameter int REF_BITS = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ras_n,
  input logic                ucas_n,
  input logic                lcas_n,
  input logic                we_n,
  input logic                oe_n,
  input logic                dq_drive_lo,
  input logic                dq_drive_hi,
  input logic [REF_BITS-1:0] cbr_row
);
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && ucas_n && lcas_n) |=> (!dq_drive_lo && !dq_drive_hi)); // R1

  AST_ROW_ONLY_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && ucas_n && lcas_n) |=> $stable(cbr_row)); // R2

  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (!dq_drive_lo && !dq_drive_hi)); // R9

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> (!dq_drive_lo && !dq_drive_hi)); // R11

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cbr_row) |-> (cbr_row == REF_BITS'($past(cbr_row) + REF_BITS'(1)))); // R6
endmodule

bind dram_strobe_model dram_strobe_model_chk #(.REF_BITS(REF_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
  .we_n(we_n), .oe_n(oe_n), .dq_drive_lo(dq_drive_lo), .dq_drive_hi(dq_drive_hi),
  .cbr_row(cbr_row)
);

// File: tb/dram_strobe_model_bench.sv
`timescale 1ns/100ps
module dram_strobe_model_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic        dq_drive_lo, dq_drive_hi;
  logic [8:0]  cbr_row;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_strobe_model u_dram_strobe_model (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_drive_lo(dq_drive_lo), .dq_drive_hi(dq_drive_hi), .cbr_row(cbr_row)
  );

  // {write, row[8:0], col[8:0], lanes[1:0], data[15:0]}; lanes bit0 = low byte
  localparam int NV = 12;
  localparam logic [36:0] VECS [NV] = '{
    {1'b1, 9'd1,  9'd2,  2'b11, 16'hA5C3},
    {1'b0, 9'd1,  9'd2,  2'b11, 16'hA5C3},
    {1'b1, 9'd1,  9'd2,  2'b01, 16'h1177},
    {1'b0, 9'd1,  9'd2,  2'b11, 16'hA577},
    {1'b1, 9'd1,  9'd2,  2'b10, 16'h3C99},
    {1'b0, 9'd1,  9'd2,  2'b01, 16'h3C77},
    {1'b0, 9'd1,  9'd2,  2'b10, 16'h3C77},
    {1'b1, 9'd3,  9'd15, 2'b11, 16'hBEEF},
    {1'b0, 9'd3,  9'd15, 2'b11, 16'hBEEF},
    {1'b0, 9'd1,  9'd2,  2'b11, 16'h3C77},
    {1'b1, 9'd19, 9'd2,  2'b11, 16'h1234},
    {1'b0, 9'd3,  9'd18, 2'b11, 16'h1234}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic open_row(logic [8:0] r);
    addr = r; ras_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic close_row();
    ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    ras_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cas_read(logic [8:0] c, logic [1:0] m);
    addr = c; we_n = 1'b1; oe_n = 1'b0; lcas_n = ~m[0]; ucas_n = ~m[1];
    @(negedge clk);
  endtask

  task automatic cas_write(logic [8:0] c, logic [1:0] m, logic [15:0] d);
    addr = c; we_n = 1'b0; dq_in = d; lcas_n = ~m[0]; ucas_n = ~m[1];
    @(negedge clk);
    lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cbr_cycle();
    lcas_n = 1'b0; ucas_n = 1'b0; we_n = 1'b0; dq_in = 16'hFFFF;
    @(negedge clk);
    ras_n = 1'b0;
    @(negedge clk);
    ras_n = 1'b1;
    @(negedge clk);
    lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_word(logic [8:0] r, logic [8:0] c, logic [15:0] exp, string tag);
    open_row(r);
    cas_read(c, 2'b11);
    check(tag, dq_out, exp);
    close_row();
  endtask

  initial begin
    logic [8:0] cnt0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset drives", {dq_drive_hi, dq_drive_lo}, 2'b00);
    check("R1 reset counter", cbr_row, 9'd0);

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VECS[i];
      open_row(v[35:27]);
      if (v[36]) begin
        cas_write(v[26:18], v[17:16], v[15:0]);
      end else begin
        cas_read(v[26:18], v[17:16]);
        check("R3/R4/R8 lane enables", {dq_drive_hi, dq_drive_lo}, v[17:16]);
        check("R3/R4/R8 read data", dq_out,
              {v[17] ? v[15:8] : 8'h00, v[16] ? v[7:0] : 8'h00});
      end
      close_row();
    end

    // R5: WE and OE both high
    open_row(9'd1);
    addr = 9'd2; we_n = 1'b1; oe_n = 1'b1; lcas_n = 1'b0; ucas_n = 1'b0;
    @(negedge clk);
    check("R5 no drive with oe high", {dq_drive_hi, dq_drive_lo}, 2'b00);
    close_row();

    // R11: early write never drives
    open_row(9'd1);
    addr = 9'd5; we_n = 1'b0; oe_n = 1'b0; dq_in = 16'h5A5A; lcas_n = 1'b0; ucas_n = 1'b0;
    @(negedge clk);
    check("R11 early write drives", {dq_drive_hi, dq_drive_lo}, 2'b00);
    check("R11 early write dq_out", dq_out, 16'h0000);
    close_row();

    // R10 page mode, R9 data held while CAS high
    open_row(9'd1);
    cas_read(9'd2, 2'b11);
    check("R10 page first column", dq_out, 16'h3C77);
    lcas_n = 1'b1; ucas_n = 1'b1;
    @(negedge clk);
    check("R9 held drives with CAS high", {dq_drive_hi, dq_drive_lo}, 2'b11);
    check("R9 held data with CAS high", dq_out, 16'h3C77);
    cas_read(9'd5, 2'b11);
    check("R10 page second column", dq_out, 16'h5A5A);
    close_row();
    check("R1 drives off after close", {dq_drive_hi, dq_drive_lo}, 2'b00);

    // R9 OE rise turns drives off
    open_row(9'd1);
    cas_read(9'd2, 2'b11);
    lcas_n = 1'b1; ucas_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b1;
    @(negedge clk);
    check("R9 drives off after oe rise", {dq_drive_hi, dq_drive_lo}, 2'b00);
    close_row();

    // R7 read-modify-write
    open_row(9'd1);
    cas_read(9'd2, 2'b11);
    check("R7 old data first", dq_out, 16'h3C77);
    we_n = 1'b0; dq_in = 16'hD00D;
    @(negedge clk);
    check("R7 drives off on write", {dq_drive_hi, dq_drive_lo}, 2'b00);
    close_row();
    read_word(9'd1, 9'd2, 16'hD00D, "R7 new data stored");

    // R2 row-only refresh
    cnt0 = cbr_row;
    addr = 9'd1; we_n = 1'b0; dq_in = 16'hEEEE; ras_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 no drive in row refresh", {dq_drive_hi, dq_drive_lo}, 2'b00);
    end
    close_row();
    check("R2 counter unchanged", cbr_row, cnt0);
    read_word(9'd1, 9'd2, 16'hD00D, "R2 data unchanged");

    // R6 counter refresh
    cbr_cycle();
    check("R6 counter after one refresh", cbr_row, 9'd1);
    check("R6 no drive in refresh", {dq_drive_hi, dq_drive_lo}, 2'b00);
    read_word(9'd1, 9'd2, 16'hD00D, "R6 no write in refresh");
    for (int k = 1; k < 511; k++) cbr_cycle();
    check("R6 counter at 511", cbr_row, 9'd511);
    cbr_cycle();
    check("R6 counter wraps to 0", cbr_row, 9'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule